// File: doc/BRIEF.md
# Ready-Latency-One Stream Hold Stage

This block is a single register stage placed in a streaming path where both sides use backpressure with a ready latency of one cycle. Each beat carries a data word together with four control flags: valid, sync, start-of-packet (sop) and end-of-packet (eop). The downstream ready is passed upstream as a plain wire. Because of the one-cycle latency, a producer may still deliver a beat in the cycle in which ready drops. The stage catches that beat, keeps it through the stall, and sends it out in the cycle after ready comes back. It does not wait for a later input beat to push it along.

Besides the registered output, the stage also exposes a "pending" view. This is the beat that would be registered if ready were high. It is either the incoming beat or the held one, and it is not gated by ready. Surrounding logic can base its flow-control decision on the pending view without forming a combinational path through ready. When ready is held high permanently, no beat is ever held and the stage behaves as a one-cycle delay register.

Top module: `rl1_hold_stage`

## Requirements
- R1: `in_ready_o` equals `out_ready_i` in the same cycle, with no register between them.
- R2: In the cycle after a clock edge at which the pending beat is valid and `out_ready_i` is high, `out_valid_o` is high and `out_data_o`, `out_sync_o`, `out_sop_o` and `out_eop_o` carry that pending beat. After any other edge, `out_valid_o` is low.
- R3: An input beat with `in_valid_i` high while `out_ready_i` is low is held. From the next cycle on, `pend_valid_o` stays high until the edge at which ready is high again. Each pending flag (valid, sync, sop, eop) is the OR of the input flag and the matching held flag.
- R4: `pend_data_o` equals `in_data_i` when `in_valid_i` is high. Otherwise it equals the last captured word, which is the word on `out_data_o`. During a stall, this is the held beat's data.
- R5: A held beat, including one that carries eop, appears on the registered output in the cycle after `out_ready_i` returns high, with no further input beat needed.
- R6: With `out_ready_i` high in every cycle, each input beat appears on the output exactly one cycle later, with its flags unchanged.
- R7: The active-low asynchronous reset `rst_ni` clears all output flags and any held beat. While it is low, `out_valid_o` and `pend_valid_o` are low, provided `in_valid_i` is low.
- R8: `out_valid_o` is high only in a cycle that follows a cycle in which `out_ready_i` was high.
- R9: Every accepted input beat leaves the output exactly once, in arrival order, with its data and flags intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | DATA_W | Input data word |
| in_valid_i | input | 1 | Input beat valid |
| in_sync_i | input | 1 | Input sync flag |
| in_sop_i | input | 1 | Input start-of-packet flag |
| in_eop_i | input | 1 | Input end-of-packet flag |
| in_ready_o | output | 1 | Ready to the producer (copy of out_ready_i) |
| out_ready_i | input | 1 | Ready from the consumer |
| out_data_o | output | DATA_W | Registered output data |
| out_valid_o | output | 1 | Registered output valid |
| out_sync_o | output | 1 | Registered output sync |
| out_sop_o | output | 1 | Registered output start-of-packet |
| out_eop_o | output | 1 | Registered output end-of-packet |
| pend_data_o | output | DATA_W | Pending data word, not gated by ready |
| pend_valid_o | output | 1 | Pending valid, not gated by ready |
| pend_sync_o | output | 1 | Pending sync |
| pend_sop_o | output | 1 | Pending start-of-packet |
| pend_eop_o | output | 1 | Pending end-of-packet |

## Verification
The assertions assume a producer that obeys the one-cycle ready latency. It raises `in_valid_i` only in a cycle that follows a cycle with `in_ready_o` high. As a result, a fresh input beat never meets a held beat, and the held word stays unchanged through a stall. The stimulus follows this rule in every phase: random valid is gated by the previous cycle's ready, and ready itself is random in bursts. Directed sequences cover a single-beat eop packet caught as ready falls, a phase with ready always high, and a reset applied while a beat is held.

// File: rtl/rl1_pkg.sv
`timescale 1ns/1ps
package rl1_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  localparam int unsigned FLG_VALID = 0;
  localparam int unsigned FLG_SYNC  = 1;
  localparam int unsigned FLG_SOP   = 2;
  localparam int unsigned FLG_EOP   = 3;

  typedef logic [NUM_FLAGS-1:0] flags_t;
endpackage

// File: rtl/rl1_flag_hold.sv
`timescale 1ns/1ps
// Remembers one control flag that arrived while ready was low.
module rl1_flag_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic flag_i,
  output logic hold_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_o <= 1'b0;
    else if (ready_i) hold_o <= 1'b0;
    else if (flag_i)  hold_o <= 1'b1;
  end
endmodule

// File: rtl/rl1_pend_mux.sv
`timescale 1ns/1ps
module rl1_pend_mux
  import rl1_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] in_data_i,
  input  flags_t            in_flags_i,
  input  flags_t            hold_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] pend_data_o,
  output flags_t            pend_flags_o,
  output flags_t            next_flags_o
);
  // The held word lives in the output data register.
  assign pend_data_o  = in_flags_i[FLG_VALID] ? in_data_i : reg_data_i;
  assign pend_flags_o = in_flags_i | hold_i;
  assign next_flags_o = pend_flags_o & {NUM_FLAGS{ready_i}};
endmodule

// File: rtl/rl1_out_reg.sv
`timescale 1ns/1ps
module rl1_out_reg
  import rl1_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  flags_t            flags_i,
  output logic [DATA_W-1:0] data_o,
  output flags_t            flags_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= flags_i;
  end

  // Data path carries no reset.
  always_ff @(posedge clk_i) begin
    if (load_i) data_o <= data_i;
  end
endmodule

// File: rtl/rl1_hold_stage.sv
`timescale 1ns/1ps
module rl1_hold_stage
  import rl1_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_valid_i,
  input  logic              in_sync_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              in_ready_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_valid_o,
  output logic              out_sync_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] pend_data_o,
  output logic              pend_valid_o,
  output logic              pend_sync_o,
  output logic              pend_sop_o,
  output logic              pend_eop_o
);
  flags_t in_flags, hold_q, pend_flags, next_flags, out_flags;

  assign in_ready_o = out_ready_i;

  always_comb begin
    in_flags            = '0;
    in_flags[FLG_VALID] = in_valid_i;
    in_flags[FLG_SYNC]  = in_sync_i;
    in_flags[FLG_SOP]   = in_sop_i;
    in_flags[FLG_EOP]   = in_eop_i;
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_hold
    rl1_flag_hold u_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ready_i(out_ready_i),
      .flag_i (in_flags[g]),
      .hold_o (hold_q[g])
    );
  end

  rl1_pend_mux #(.DATA_W(DATA_W)) u_mux (
    .in_data_i   (in_data_i),
    .in_flags_i  (in_flags),
    .hold_i      (hold_q),
    .reg_data_i  (out_data_o),
    .ready_i     (out_ready_i),
    .pend_data_o (pend_data_o),
    .pend_flags_o(pend_flags),
    .next_flags_o(next_flags)
  );

  rl1_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pend_flags[FLG_VALID]),
    .data_i (pend_data_o),
    .flags_i(next_flags),
    .data_o (out_data_o),
    .flags_o(out_flags)
  );

  assign out_valid_o  = out_flags[FLG_VALID];
  assign out_sync_o   = out_flags[FLG_SYNC];
  assign out_sop_o    = out_flags[FLG_SOP];
  assign out_eop_o    = out_flags[FLG_EOP];
  assign pend_valid_o = pend_flags[FLG_VALID];
  assign pend_sync_o  = pend_flags[FLG_SYNC];
  assign pend_sop_o   = pend_flags[FLG_SOP];
  assign pend_eop_o   = pend_flags[FLG_EOP];
endmodule

// File: rtl/rl1_hold_stage_chk.sv
`timescale 1ns/1ps
module rl1_hold_stage_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_eop_i,
  input logic              out_ready_i,
  input logic              out_valid_i,
  input logic [DATA_W-1:0] out_data_i,
  input logic              pend_valid_i,
  input logic              pend_eop_i,
  input logic              hold_valid_i
);
  p_out_after_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i |-> $past(out_ready_i));

  p_pend_to_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_valid_i && out_ready_i) |=> out_valid_i);

  p_stall_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !out_ready_i) |=> hold_valid_i);

  p_flush_on_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid_i && out_ready_i) |=> (out_valid_i && !hold_valid_i));

  p_eop_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_eop_i && !out_ready_i) |=> pend_eop_i);

  p_held_word_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_valid_i && !out_ready_i) |=> $stable(out_data_i));

  // Producer honours the one-cycle latency (R3 input assumption).
  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && hold_valid_i));
endmodule

bind rl1_hold_stage rl1_hold_stage_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_eop_i    (in_eop_i),
  .out_ready_i (out_ready_i),
  .out_valid_i (out_valid_o),
  .out_data_i  (out_data_o),
  .pend_valid_i(pend_valid_o),
  .pend_eop_i  (pend_eop_o),
  .hold_valid_i(hold_q[rl1_pkg::FLG_VALID])
);

// File: tb/rl1_hold_stage_bench.sv
`timescale 1ns/1ps
module rl1_hold_stage_bench;
  localparam int unsigned DATA_W = 16;

  typedef struct packed {
    logic [DATA_W-1:0] d;
    logic sync;
    logic sop;
    logic eop;
  } beat_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_valid = 1'b0, in_sync = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready_o;
  logic [DATA_W-1:0] out_data_o, pend_data_o;
  logic out_valid_o, out_sync_o, out_sop_o, out_eop_o;
  logic pend_valid_o, pend_sync_o, pend_sop_o, pend_eop_o;

  always #5 clk = ~clk;

  rl1_hold_stage #(.DATA_W(DATA_W)) u_rl1_hold_stage (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_sync_i(in_sync),
    .in_sop_i(in_sop), .in_eop_i(in_eop), .in_ready_o(in_ready_o),
    .out_ready_i(out_ready),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .out_sync_o(out_sync_o),
    .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .pend_data_o(pend_data_o), .pend_valid_o(pend_valid_o), .pend_sync_o(pend_sync_o),
    .pend_sop_o(pend_sop_o), .pend_eop_o(pend_eop_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  beat_t sb_q[$];
  bit    has_held = 0;
  beat_t held_b;
  bit    exp_v = 0;
  beat_t exp_b;
  bit    prev_rdy = 0;
  string out_tag = "R2";

  // Packet generator
  int seq = 0, pkt_no = 0, beat_idx = 0, pkt_len = 3;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h t=%0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic gen_beat(output beat_t b);
    b.d    = seq[DATA_W-1:0];
    b.sop  = (beat_idx == 0);
    b.eop  = (beat_idx == pkt_len - 1);
    b.sync = b.sop && (pkt_no % 3 == 0);
    seq++;
    beat_idx++;
    if (beat_idx == pkt_len) begin
      beat_idx = 0;
      pkt_no++;
      pkt_len = 1 + int'($urandom % 5);
    end
  endtask

  task automatic step(input bit rdy, input bit vld_req);
    beat_t b, cur, got;
    bit vld, pv;
    @(negedge clk);
    // registered outputs from the last edge
    check(out_valid_o === exp_v, out_tag, "out_valid", 32'(out_valid_o), 32'(exp_v));
    if (out_valid_o === 1'b1)
      check(prev_rdy, "R8", "out_valid after low ready", 32'(out_valid_o), 32'(prev_rdy));
    if (exp_v) begin
      got = '{d: out_data_o, sync: out_sync_o, sop: out_sop_o, eop: out_eop_o};
      check(got === exp_b, out_tag, "out beat", 32'(got), 32'(exp_b));
      if (sb_q.size() == 0)
        check(1'b0, "R9", "output with empty scoreboard", 32'(got), 32'(0));
      else begin
        beat_t want;
        want = sb_q.pop_front();
        check(got === want, "R9", "order/content", 32'(got), 32'(want));
      end
    end
    vld = vld_req && prev_rdy;
    if (vld) begin
      gen_beat(b);
      sb_q.push_back(b);
    end else begin
      b = '{d: DATA_W'($urandom), sync: 1'b0, sop: 1'b0, eop: 1'b0};
    end
    out_ready = rdy;
    in_valid = vld;
    in_data = b.d; in_sync = b.sync; in_sop = b.sop; in_eop = b.eop;
    #1;
    check(in_ready_o === rdy, "R1", "ready passthrough", 32'(in_ready_o), 32'(rdy));
    pv = vld || has_held;
    cur = vld ? b : held_b;
    check(pend_valid_o === pv, "R3", "pend_valid", 32'(pend_valid_o), 32'(pv));
    if (pv) begin
      check({pend_sync_o, pend_sop_o, pend_eop_o} === {cur.sync, cur.sop, cur.eop},
            "R3", "pend flags", 32'({pend_sync_o, pend_sop_o, pend_eop_o}),
            32'({cur.sync, cur.sop, cur.eop}));
      check(pend_data_o === cur.d, "R4", "pend_data", 32'(pend_data_o), 32'(cur.d));
      if (!vld)
        check(pend_data_o === out_data_o, "R4", "pend_data vs out_data",
              32'(pend_data_o), 32'(out_data_o));
    end
    exp_v = pv && rdy;
    exp_b = cur;
    if (pv && !rdy) begin
      has_held = 1;
      held_b = cur;
    end else begin
      has_held = 0;
    end
    prev_rdy = rdy;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid_o === 1'b0, "R7", "out_valid in reset", 32'(out_valid_o), 0);
    check(pend_valid_o === 1'b0, "R7", "pend_valid in reset", 32'(pend_valid_o), 0);
    check({out_sync_o, out_sop_o, out_eop_o} === 3'b000, "R7", "out flags in reset",
          32'({out_sync_o, out_sop_o, out_eop_o}), 0);
    rst_ni = 1'b1;

    // R6: ready always high
    out_tag = "R6";
    step(1, 0);
    for (int i = 0; i < 300; i++) step(1, ($urandom % 4) != 0);

    // R5: single-beat eop packet caught as ready falls
    out_tag = "R5";
    step(1, 0);
    beat_idx = 0; pkt_len = 1;
    step(0, 1);
    for (int i = 0; i < 4; i++) step(0, 0);
    step(1, 0);
    step(1, 0);
    check(exp_v == 1'b0 && sb_q.size() == 0, "R5", "eop flushed", 32'(sb_q.size()), 0);

    // R2/R3/R8/R9: random ready bursts
    out_tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      bit r;
      r = (i % 64 < 32) ? (($urandom % 4) != 0) : (($urandom % 3) == 0);
      step(r, ($urandom % 3) != 0);
    end

    // R7: reset while a beat is held
    step(1, 0);
    step(0, 1);
    @(negedge clk);
    rst_ni = 1'b0;
    in_valid = 1'b0; in_sync = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    #1;
    check(out_valid_o === 1'b0, "R7", "out_valid after reset", 32'(out_valid_o), 0);
    check(pend_valid_o === 1'b0, "R7", "held beat cleared", 32'(pend_valid_o), 0);
    sb_q.delete();
    has_held = 0; exp_v = 0; prev_rdy = 0;
    step(1, 0);
    rst_ni = 1'b1;
    step(1, 0);
    for (int i = 0; i < 200; i++) step(($urandom % 2) != 0, 1);

    // drain
    out_tag = "R9";
    for (int i = 0; i < 4; i++) step(1, 0);
    check(sb_q.size() == 0, "R9", "scoreboard empty", 32'(sb_q.size()), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule